// File: doc/BRIEF.md
# Two-per-word colour lookup table

This block holds a 256-entry colour lookup table for a display pipeline. The bus side sees it as 128 words of 32 bits, each word carrying two 16-bit colour entries. The pixel side presents an 8-bit index and receives 24-bit colour one cycle later. Each of the three 5-bit components becomes an 8-bit channel, padded with zeros in its low bits.

A control input picks the component order. Either the lowest field of an entry is red and the upper field is blue, or the two are exchanged. The top bit of each entry is carried in storage and returned on readback, but it never changes the colour. A bus write and a pixel lookup may happen in the same cycle, and neither waits for the other.

Top module: `clut_palette`

## Requirements
- R1: Word address `a` holds entry `2a` in bits 15:0 and entry `2a+1` in bits 31:16. Bit 0 of `pix_idx` picks the half and the upper index bits pick the word.
- R2: Within a 16-bit entry, bits 4:0 form the low colour field, bits 9:5 form green and bits 14:10 form the high colour field. Bit 15 has no effect on `red`, `green` or `blue`.
- R3: Each 5-bit field appears on its 8-bit channel as the field in bits 7:3, with bits 2:0 zero.
- R4: With `swap_rb` low, the low field drives `red` and the high field drives `blue`. With `swap_rb` high, the low field drives `blue` and the high field drives `red`. The `swap_rb` value used is the one present in the lookup cycle.
- R5: A lookup presented with `pix_valid` high in cycle T gives `rgb_valid` high and the colour in cycle T+1. In a cycle after one without a lookup, `rgb_valid` is low and the colour outputs keep their previous value.
- R6: `bus_rdata` in cycle T+1 equals the complete 32-bit word at `bus_addr` from cycle T, exactly as written, including bits 15 and 31.
- R7: A write in cycle T is seen by lookups and reads from cycle T+1 onward. A lookup or read of the same word in cycle T returns the previous contents.
- R8: Writes and lookups may occur together in every cycle with no stall, and each lookup returns the table contents as they stood in its own cycle.
- R9: While `rst_n` is low at a clock edge, `rgb_valid`, `red`, `green`, `blue` and `bus_rdata` are all cleared to zero, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 7 | Word address for bus read and write |
| bus_wr_en | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 32 | Word to store (two entries) |
| bus_rdata | output | 32 | Registered raw word from the previous cycle's address |
| pix_valid | input | 1 | Lookup request |
| pix_idx | input | 8 | Entry index for the lookup |
| swap_rb | input | 1 | Exchange red and blue fields |
| rgb_valid | output | 1 | Colour outputs carry a new lookup result |
| red | output | 8 | Expanded red channel |
| green | output | 8 | Expanded green channel |
| blue | output | 8 | Expanded blue channel |

## Verification
The bench builds the block with its default 8-bit index. This gives all 128 words and both halves of each word. The index space is small enough to sweep completely in both component orders, and every word can be read back. It also covers the corner cases in which a write collides with a lookup or read of the same word in one cycle. Some entries set their top bits so the bench can show those bits have no effect on colour. Randomized traffic then mixes writes, reads and lookups in every cycle against a behavioural table model.

// File: rtl/clut_pkg.sv
// Package: shared constants for the colour lookup table.
// Assumes three equal-width colour fields per entry plus one flag bit.
package clut_pkg;
    localparam int COMP_W  = 5;              // stored bits per colour field
    localparam int CH_W    = 8;              // output bits per channel
    localparam int NCOMP   = 3;              // fields per entry
    localparam int ENTRY_W = 16;             // stored bits per entry
    localparam int PER_WORD = 2;             // entries packed per bus word
    localparam int WORD_W  = ENTRY_W * PER_WORD;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;
endpackage

// File: rtl/clut_word_store.sv
// Module: word array with one write port and two registered read ports.
// Purpose: keeps the raw packed words. The bus port reads every cycle and the
// pixel port reads only when asked. Both read ports return the contents held
// before a write in the same cycle (read-before-write).
// Assumes: the array itself is not reset; only the read registers are.
module clut_word_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bus_q,
    input  logic              px_en,
    input  logic [ADDR_W-1:0] px_addr,
    output logic [DATA_W-1:0] px_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Store a bus word; writes are held off during reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Register the bus readback word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= words[wr_addr];
        end
    end

    // Register the pixel word only on a lookup, so it holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q <= '0;
        end else if (px_en) begin
            px_q <= words[px_addr];
        end
    end
endmodule

// File: rtl/clut_half_pick.sv
// Module: chooses one packed entry out of a word.
// Purpose: the low entry serves even indices and the high entry odd ones.
// Assumes: the select has been registered in step with the word.
module clut_half_pick
    import clut_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic               odd,
    output logic [ENTRY_W-1:0] entry
);
    // Pick the half addressed by the index's lowest bit.
    always_comb begin
        entry = odd ? word[ENTRY_W +: ENTRY_W] : word[0 +: ENTRY_W];
    end
endmodule

// File: rtl/clut_expand.sv
// Module: widens packed colour fields to output channels.
// Purpose: each field is shifted to the top of its channel with zero fill,
// and the outer two fields may be exchanged. The flag bit above the fields
// is not used.
// Assumes: CH_W >= COMP_W.
module clut_expand
    import clut_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               swap_rb,
    output rgb_t               rgb
);
    localparam int PAD_W = CH_W - COMP_W;

    logic [CH_W-1:0] chan [NCOMP];

    // Widen every field the same way.
    for (genvar k = 0; k < NCOMP; k++) begin : g_field
        always_comb begin
            chan[k] = {entry[k*COMP_W +: COMP_W], {PAD_W{1'b0}}};
        end
    end

    // Route the outer fields to red and blue according to the order select.
    always_comb begin
        rgb.green = chan[1];
        rgb.red   = swap_rb ? chan[NCOMP-1] : chan[0];
        rgb.blue  = swap_rb ? chan[0]       : chan[NCOMP-1];
    end
endmodule

// File: rtl/clut_palette.sv
// Module: colour lookup table top level.
// Purpose: bus-writable packed palette with a one-cycle pixel lookup that
// returns expanded 24-bit colour, plus raw word readback.
// Assumes: synchronous active-low reset; lookup and write never stall.
module clut_palette
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-2:0]    bus_addr,
    input  logic                bus_wr_en,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                pix_valid,
    input  logic [IDX_W-1:0]    pix_idx,
    input  logic                swap_rb,
    output logic                rgb_valid,
    output logic [CH_W-1:0]     red,
    output logic [CH_W-1:0]     green,
    output logic [CH_W-1:0]     blue
);
    localparam int WORD_AW = IDX_W - 1;

    logic [WORD_W-1:0]  px_word;
    logic [ENTRY_W-1:0] px_entry;
    logic               odd_q;
    logic               swap_q;
    logic               valid_q;
    rgb_t               rgb;

    // Track lookup validity and the per-lookup selects beside the word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            odd_q   <= 1'b0;
            swap_q  <= 1'b0;
        end else begin
            valid_q <= pix_valid;
            if (pix_valid) begin
                odd_q  <= pix_idx[0];
                swap_q <= swap_rb;
            end
        end
    end

    clut_word_store #(
        .ADDR_W (WORD_AW),
        .DATA_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (bus_addr),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wdata),
        .bus_q   (bus_rdata),
        .px_en   (pix_valid),
        .px_addr (pix_idx[IDX_W-1:1]),
        .px_q    (px_word)
    );

    clut_half_pick u_pick (
        .word  (px_word),
        .odd   (odd_q),
        .entry (px_entry)
    );

    clut_expand u_expand (
        .entry   (px_entry),
        .swap_rb (swap_q),
        .rgb     (rgb)
    );

    // Drive the colour outputs from the expanded entry.
    always_comb begin
        rgb_valid = valid_q;
        red       = rgb.red;
        green     = rgb.green;
        blue      = rgb.blue;
    end
endmodule

// File: rtl/clut_palette_chk.sv
// Module: property checker bound to the lookup table top level.
// Purpose: watches the ports for timing, padding, readback and reset rules.
module clut_palette_chk
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-2:0]  bus_addr,
    input logic              bus_wr_en,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              pix_valid,
    input logic              rgb_valid,
    input logic [CH_W-1:0]   red,
    input logic [CH_W-1:0]   green,
    input logic [CH_W-1:0]   blue
);
    localparam int PAD_W = CH_W - COMP_W;

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> rgb_valid);

    a_r5_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !rgb_valid);

    a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid |-> (red[PAD_W-1:0] == '0 && green[PAD_W-1:0] == '0
                       && blue[PAD_W-1:0] == '0));

    a_r6_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en ##1 (!bus_wr_en && bus_addr == $past(bus_addr)))
        |=> bus_rdata == $past(bus_wdata, 2));

    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!rgb_valid && bus_rdata == '0 && red == '0
                    && green == '0 && blue == '0));
endmodule

bind clut_palette clut_palette_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_valid (pix_valid),
    .rgb_valid (rgb_valid),
    .red       (red),
    .green     (green),
    .blue      (blue)
);

// File: tb/clut_palette_bench.sv
// Bench: behavioural table model compared with the outputs every clock.
module clut_palette_bench;
    localparam int IDX_W = 8;
    localparam int WORDS = 1 << (IDX_W - 1);

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  bus_addr;
    logic        bus_wr_en;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pix_valid;
    logic [7:0]  pix_idx;
    logic        swap_rb;
    logic        rgb_valid;
    logic [7:0]  red, green, blue;

    always #10 clk = ~clk;

    clut_palette #(.IDX_W(IDX_W)) u_clut_palette (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_valid(pix_valid),
        .pix_idx(pix_idx), .swap_rb(swap_rb), .rgb_valid(rgb_valid),
        .red(red), .green(green), .blue(blue)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] model [WORDS];
    bit          known [WORDS];
    logic        exp_valid;
    logic [23:0] exp_rgb;
    logic [31:0] exp_rd;
    bit          exp_rd_known;
    string       cur_tag;

    function automatic logic [23:0] colour(logic [31:0] w, bit odd, bit sw);
        logic [15:0] e;
        logic [7:0] lo, mid, hi;
        e   = odd ? w[31:16] : w[15:0];
        lo  = {e[4:0], 3'b000};
        mid = {e[9:5], 3'b000};
        hi  = {e[14:10], 3'b000};
        return sw ? {hi, mid, lo} : {lo, mid, hi};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(cur_tag, "rgb_valid", {31'd0, rgb_valid}, {31'd0, exp_valid});
        check(cur_tag, "colour", {8'd0, red, green, blue}, {8'd0, exp_rgb});
        if (exp_rd_known) check(cur_tag, "bus_rdata", bus_rdata, exp_rd);
    endtask

    task automatic step(string tag, bit wr, logic [6:0] a, logic [31:0] d,
                        bit pv, logic [7:0] idx, bit sw);
        @(negedge clk);
        compare();
        bus_wr_en = wr; bus_addr = a; bus_wdata = d;
        pix_valid = pv; pix_idx = idx; swap_rb = sw;
        cur_tag = tag;
        exp_valid = pv;
        if (pv) exp_rgb = colour(model[idx[7:1]], idx[0], sw);
        exp_rd_known = known[a];
        exp_rd = model[a];
        if (wr) begin
            model[a] = d;
            known[a] = 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            model[i] = '0;
            known[i] = 1'b0;
        end
        rst_n = 1'b0; bus_wr_en = 0; bus_addr = '0; bus_wdata = '0;
        pix_valid = 0; pix_idx = '0; swap_rb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs cleared while in reset
        check("R9", "reset rgb_valid", {31'd0, rgb_valid}, 32'd0);
        check("R9", "reset colour", {8'd0, red, green, blue}, 32'd0);
        check("R9", "reset bus_rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        exp_valid = 0; exp_rgb = '0; exp_rd = '0; exp_rd_known = 0; cur_tag = "R9";

        // R1: fill every word with distinct two-entry patterns
        for (int w = 0; w < WORDS; w++)
            step("R1", 1, 7'(w), (32'(w) * 32'h9E37_79B1) ^ 32'h8001_4A5C, 0, 0, 0);
        // R6: raw readback of every word
        for (int w = 0; w < WORDS; w++) step("R6", 0, 7'(w), 0, 0, 0, 0);
        // R1: every index, normal order
        for (int i = 0; i < 256; i++) step("R1", 0, 0, 0, 1, 8'(i), 0);
        // R4: every index, exchanged order
        for (int i = 0; i < 256; i++) step("R4", 0, 0, 0, 1, 8'(i), 1);
        // R2: flag bits set versus clear give identical colour
        step("R2", 1, 7'd5, 32'h8000_8000 | 32'h1234_5678, 0, 0, 0);
        step("R2", 0, 7'd5, 0, 1, 8'd10, 0);
        step("R2", 0, 7'd5, 0, 1, 8'd11, 0);
        step("R2", 1, 7'd5, 32'h1234_5678, 0, 0, 0);
        step("R2", 0, 7'd5, 0, 1, 8'd10, 0);
        step("R2", 0, 7'd5, 0, 1, 8'd11, 0);
        // R3: full-scale and single-bit fields
        step("R3", 1, 7'd7, 32'hFFFF_FFFF, 0, 0, 0);
        step("R3", 1, 7'd8, 32'h0421_0001, 1, 8'd14, 0);
        step("R3", 0, 7'd8, 0, 1, 8'd16, 0);
        step("R3", 0, 7'd8, 0, 1, 8'd17, 1);
        // R7: same-cycle write and lookup/read of one word, then next cycle
        step("R7", 1, 7'd20, 32'hABCD_1357, 1, 8'd40, 0);
        step("R7", 0, 7'd20, 0, 1, 8'd40, 0);
        step("R7", 1, 7'd20, 32'h0F0F_7C1F, 1, 8'd41, 1);
        step("R7", 0, 7'd20, 0, 1, 8'd41, 1);
        // R5: idle cycles after a lookup hold colour with valid low
        step("R5", 0, 7'd3, 0, 1, 8'd6, 0);
        for (int k = 0; k < 4; k++) step("R5", 0, 7'd3, 0, 0, 8'd200, 1);
        // R8: mixed traffic every cycle
        for (int k = 0; k < 3000; k++)
            step("R8", 1'($urandom), 7'($urandom), $urandom, 1'($urandom % 4 != 0),
                 8'($urandom), 1'($urandom));
        step("R8", 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        finish_run();
    end
endmodule